// File: doc/BRIEF.md
# Two-Register Stack Processor with Microcoded Program Store

This block is a small single-cycle processor for 16-bit data. Its whole architectural state is a top register T, a second register N and a 4-bit program counter. The program counter steps through a sixteen-word program store. Each word in the store is a control word with two fields. One field names a stack action and the other names an ALU function. On every rising clock edge, the word at the current address is executed and the counter moves on to the next address.

The processor reads data from an 8-bit switch input. A fetch pushes that value onto the two-register stack. Arithmetic and logic results always land in T. Both T and N are brought out on ports so that a display can show them. The program is a parameter. Its default is a ten-step demonstration sequence followed by six idle words.

Top module: `stk_core`

## Requirements
- R1: Raising `clr` sets T, N and the program counter to zero at once, without waiting for a clock edge. After `clr` is released, the first edge executes word 0.
- R2: The program counter advances by one on every rising edge while `clr` is low. After word 15 it wraps to word 0, so the program repeats every 16 edges.
- R3: A fetch word (action code 3) loads the switch value into T, zero-extended to 16 bits. The same edge moves the old T into N.
- R4: A duplicate word (action code 1) copies T into N and leaves T unchanged.
- R5: A swap word (action code 2) exchanges T and N.
- R6: Binary ALU words (action code 4) write `N op T` into T and leave N unchanged. The binary functions are add modulo 2^16 (function code 0), bitwise OR (code 3), and left shift of N by the full value of T (code 5). The shift gives zero when T is 16 or more.
- R7: Unary ALU words (action code 4) act on T alone and leave N unchanged. The unary functions are increment (function code 1), bitwise invert (code 2) and shift left by one (code 4).
- R8: A control word whose bits are all zero leaves T and N unchanged. A control word is 6 bits wide: the action sits in bits 5:3 and the function in bits 2:0.
- R9: The default program runs fetch, fetch, left shift, fetch, OR, double, fetch, add, invert and increment, then six all-zero words. With switch values 0x69, 0x08, 0x37 and 0xA4 at its four fetches, T reads 0xD312 after step 8, 0x2CED after step 9 and 0x2CEE after step 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every rising edge executes one control word |
| clr | input | 1 | Asynchronous active-high clear of T, N and the program counter |
| sw | input | 8 | Switch value that a fetch word samples |
| t_out | output | 16 | Current contents of the top register T |
| n_out | output | 16 | Current contents of the next register N |

## Verification
The bench targets operand order and the tie between T and N. If a design used T shifted by N instead of N shifted by T, the left-shift step of the default program would no longer give 0x6900, and the 0xD312 result would drift. A design that popped N on binary operations, or that touched N on unary ones, would fail the per-cycle comparison of N. A design that did not wrap the counter, or that did not treat the zero word as idle, would corrupt T once the first program pass ended.

Shift amounts of 16 or more must give zero. An asynchronous clear raised between edges must zero the outputs before the next edge. A second parameterised program exercises duplicate, swap and every ALU function under random switch values.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int PC_W       = 4;
    localparam int PROG_DEPTH = 1 << PC_W;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_DUP   = 3'd1,
        ACT_SWAP  = 3'd2,
        ACT_FETCH = 3'd3,
        ACT_ALU   = 3'd4
    } stk_act_e;

    typedef enum logic [2:0] {
        FN_ADD = 3'd0,
        FN_INC = 3'd1,
        FN_INV = 3'd2,
        FN_OR  = 3'd3,
        FN_DBL = 3'd4,
        FN_LSH = 3'd5
    } alu_fn_e;

    typedef struct packed {
        stk_act_e act;
        alu_fn_e  fn;
    } ctrl_t;

    typedef ctrl_t [PROG_DEPTH-1:0] prog_t;

    function automatic ctrl_t mk_word(stk_act_e a, alu_fn_e f);
        ctrl_t w;
        w.act = a;
        w.fn  = f;
        return w;
    endfunction

    function automatic logic fn_is_binary(alu_fn_e f);
        return (f == FN_ADD) || (f == FN_OR) || (f == FN_LSH);
    endfunction

    // Demonstration sequence; the remaining words stay all-zero (idle).
    function automatic prog_t default_prog();
        prog_t p;
        p     = '0;
        p[0]  = mk_word(ACT_FETCH, FN_ADD);
        p[1]  = mk_word(ACT_FETCH, FN_ADD);
        p[2]  = mk_word(ACT_ALU,   FN_LSH);
        p[3]  = mk_word(ACT_FETCH, FN_ADD);
        p[4]  = mk_word(ACT_ALU,   FN_OR);
        p[5]  = mk_word(ACT_ALU,   FN_DBL);
        p[6]  = mk_word(ACT_FETCH, FN_ADD);
        p[7]  = mk_word(ACT_ALU,   FN_ADD);
        p[8]  = mk_word(ACT_ALU,   FN_INV);
        p[9]  = mk_word(ACT_ALU,   FN_INC);
        return p;
    endfunction

endpackage

// File: rtl/stk_pc.sv
module stk_pc #(
    parameter int PC_W = 4
) (
    input  logic            clk,
    input  logic            clr,
    output logic [PC_W-1:0] pc_o
);

    logic [PC_W-1:0] pc_q;

    always_ff @(posedge clk or posedge clr) begin
        if (clr) pc_q <= '0;
        else     pc_q <= pc_q + 1'b1;
    end

    assign pc_o = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (clr)
        !clr |=> pc_q == $past(pc_q) + 1'b1);  // R2

endmodule

// File: rtl/stk_rom.sv
module stk_rom
    import stk_pkg::*;
#(
    parameter prog_t PROG = default_prog()
) (
    input  logic [PC_W-1:0] addr_i,
    output ctrl_t           word_o
);

    assign word_o = PROG[addr_i];

endmodule

// File: rtl/stk_alu.sv
module stk_alu
    import stk_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] n_i,
    input  logic [DATA_W-1:0] t_i,
    input  alu_fn_e           fn_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        case (fn_i)
            FN_ADD:  y_o = n_i + t_i;
            FN_INC:  y_o = t_i + 1'b1;
            FN_INV:  y_o = ~t_i;
            FN_OR:   y_o = n_i | t_i;
            FN_DBL:  y_o = {t_i[DATA_W-2:0], 1'b0};
            FN_LSH:  y_o = n_i << t_i;
            default: y_o = t_i;
        endcase
    end

endmodule

// File: rtl/stk_core.sv
module stk_core
    import stk_pkg::*;
#(
    parameter int    DATA_W = 16,
    parameter int    SW_W   = 8,
    parameter prog_t PROG   = default_prog()
) (
    input  logic              clk,
    input  logic              clr,
    input  logic [SW_W-1:0]   sw,
    output logic [DATA_W-1:0] t_out,
    output logic [DATA_W-1:0] n_out
);

    localparam int PAD_W = DATA_W - SW_W;

    logic [PC_W-1:0]   pc;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] sw_ext;
    logic [DATA_W-1:0] t_q, n_q, t_nxt, n_nxt;

    stk_pc #(.PC_W(PC_W)) i_pc (
        .clk  (clk),
        .clr  (clr),
        .pc_o (pc)
    );

    stk_rom #(.PROG(PROG)) i_rom (
        .addr_i (pc),
        .word_o (ctrl)
    );

    stk_alu #(.DATA_W(DATA_W)) i_alu (
        .n_i  (n_q),
        .t_i  (t_q),
        .fn_i (ctrl.fn),
        .y_o  (alu_y)
    );

    assign sw_ext = {{PAD_W{1'b0}}, sw};

    always_comb begin
        t_nxt = t_q;
        n_nxt = n_q;
        case (ctrl.act)
            ACT_DUP:   n_nxt = t_q;
            ACT_SWAP:  begin t_nxt = n_q;    n_nxt = t_q; end
            ACT_FETCH: begin t_nxt = sw_ext; n_nxt = t_q; end
            ACT_ALU:   t_nxt = alu_y;
            default:   ;
        endcase
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            t_q <= '0;
            n_q <= '0;
        end else begin
            t_q <= t_nxt;
            n_q <= n_nxt;
        end
    end

    assign t_out = t_q;
    assign n_out = n_q;

    AST_FETCH_PUSH: assert property (@(posedge clk) disable iff (clr)
        ctrl.act == ACT_FETCH |=> (t_q == {{PAD_W{1'b0}}, $past(sw)}) && (n_q == $past(t_q)));  // R3
    AST_DUP_COPY: assert property (@(posedge clk) disable iff (clr)
        ctrl.act == ACT_DUP |=> (n_q == $past(t_q)) && $stable(t_q));  // R4
    AST_SWAP_XCHG: assert property (@(posedge clk) disable iff (clr)
        ctrl.act == ACT_SWAP |=> (t_q == $past(n_q)) && (n_q == $past(t_q)));  // R5
    AST_BINARY_KEEPS_N: assert property (@(posedge clk) disable iff (clr)
        (ctrl.act == ACT_ALU) && fn_is_binary(ctrl.fn) |=> $stable(n_q));  // R6
    AST_UNARY_KEEPS_N: assert property (@(posedge clk) disable iff (clr)
        (ctrl.act == ACT_ALU) && !fn_is_binary(ctrl.fn) |=> $stable(n_q));  // R7
    AST_ZERO_WORD_IDLE: assert property (@(posedge clk) disable iff (clr)
        ctrl == '0 |=> $stable(t_q) && $stable(n_q));  // R8

endmodule

// File: tb/test_stk_core.sv
module test_stk_core;
    import stk_pkg::*;

    localparam int CLK_NS = 8;

    function automatic prog_t build_prog_b();
        prog_t p;
        p     = '0;
        p[0]  = mk_word(ACT_FETCH, FN_ADD);
        p[1]  = mk_word(ACT_FETCH, FN_ADD);
        p[2]  = mk_word(ACT_SWAP,  FN_ADD);
        p[3]  = mk_word(ACT_DUP,   FN_ADD);
        p[4]  = mk_word(ACT_FETCH, FN_ADD);
        p[5]  = mk_word(ACT_ALU,   FN_ADD);
        p[6]  = mk_word(ACT_ALU,   FN_OR);
        p[7]  = mk_word(ACT_ALU,   FN_INC);
        p[8]  = mk_word(ACT_ALU,   FN_INV);
        p[9]  = mk_word(ACT_ALU,   FN_DBL);
        p[10] = mk_word(ACT_FETCH, FN_ADD);
        p[11] = mk_word(ACT_ALU,   FN_LSH);
        p[12] = mk_word(ACT_SWAP,  FN_ADD);
        p[14] = mk_word(ACT_DUP,   FN_ADD);
        p[15] = mk_word(ACT_FETCH, FN_ADD);
        return p;
    endfunction

    localparam prog_t PROG_B = build_prog_b();

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [7:0]  sw  = '0;
    logic [15:0] t_a, n_a, t_b, n_b;

    always #(CLK_NS/2) clk = ~clk;

    stk_core i_stk_core (
        .clk(clk), .clr(clr), .sw(sw), .t_out(t_a), .n_out(n_a)
    );

    stk_core #(.PROG(PROG_B)) i_stk_core_b (
        .clk(clk), .clr(clr), .sw(sw), .t_out(t_b), .n_out(n_b)
    );

    int n_cmp = 0;
    int n_bad = 0;

    prog_t       progs [2];
    logic [15:0] mt [2];
    logic [15:0] mn [2];
    logic [3:0]  mpc [2];
    int          msteps [2];
    string       mtag [2];

    function automatic logic [15:0] ref_alu(alu_fn_e f, logic [15:0] n, logic [15:0] t);
        case (f)
            FN_ADD: return 16'((32'(n) + 32'(t)) % 65536);
            FN_INC: return (t == 16'hFFFF) ? 16'h0000 : t + 16'd1;
            FN_INV: return t ^ 16'hFFFF;
            FN_OR:  return n | t;
            FN_DBL: return 16'((32'(t) * 2) % 65536);
            FN_LSH: return (t >= 16) ? 16'h0000 : 16'((32'(n) * (32'd1 << t[3:0])) % 65536);
            default: return t;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            mt[k] = '0; mn[k] = '0; mpc[k] = '0; msteps[k] = 0; mtag[k] = "R1";
        end
    endtask

    task automatic model_step(int k, logic [7:0] s);
        ctrl_t       w;
        logic [15:0] ot;
        w  = progs[k][mpc[k]];
        ot = mt[k];
        case (w.act)
            ACT_FETCH: begin mt[k] = {8'h00, s}; mn[k] = ot; mtag[k] = "R3"; end
            ACT_DUP:   begin mn[k] = ot; mtag[k] = "R4"; end
            ACT_SWAP:  begin mt[k] = mn[k]; mn[k] = ot; mtag[k] = "R5"; end
            ACT_ALU:   begin
                mt[k]   = ref_alu(w.fn, mn[k], ot);
                mtag[k] = fn_is_binary(w.fn) ? "R6" : "R7";
            end
            default:   mtag[k] = "R8";
        endcase
        if (msteps[k] >= 16 && mpc[k] == 4'd0) mtag[k] = "R2";
        mpc[k]    = mpc[k] + 4'd1;
        msteps[k] = msteps[k] + 1;
    endtask

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check(mtag[0], "A.T", t_a, mt[0]);
        check(mtag[0], "A.N", n_a, mn[0]);
        check(mtag[1], "B.T", t_b, mt[1]);
        check(mtag[1], "B.N", n_b, mn[1]);
    endtask

    task automatic run_cycle(logic [7:0] s);
        sw = s;
        model_step(0, s);
        model_step(1, s);
        @(negedge clk);
        compare_all();
    endtask

    task automatic async_clear();
        #1 clr = 1'b1;
        #1;
        check("R1", "A.T async", t_a, 16'h0);
        check("R1", "A.N async", n_a, 16'h0);
        check("R1", "B.T async", t_b, 16'h0);
        check("R1", "B.N async", n_b, 16'h0);
        @(negedge clk);
        @(negedge clk);
        clr = 1'b0;
        model_reset();
    endtask

    function automatic logic [7:0] rand_sw();
        logic [31:0] r;
        r = $urandom;
        return r[31] ? 8'(r % 20) : r[7:0];
    endfunction

    initial begin
        #(CLK_NS * 150000);
        n_bad++;
        $display("FAIL R2 watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] demo [10];
        void'($urandom(32'd5417));
        progs[0] = default_prog();
        progs[1] = PROG_B;
        model_reset();
        demo = '{8'h69, 8'h08, 8'h11, 8'h37, 8'h22, 8'h33, 8'hA4, 8'h44, 8'h55, 8'h66};

        @(negedge clk);
        @(negedge clk);
        check("R1", "A.T reset", t_a, 16'h0);
        check("R1", "A.N reset", n_a, 16'h0);
        clr = 1'b0;

        for (int i = 0; i < 10; i++) begin
            run_cycle(demo[i]);
            if (i == 2) check("R6", "A.T lshift", t_a, 16'h6900);
            if (i == 7) check("R9", "A.T add", t_a, 16'hD312);
            if (i == 8) check("R9", "A.T invert", t_a, 16'h2CED);
            if (i == 9) check("R9", "A.T inc", t_a, 16'h2CEE);
        end

        for (int i = 0; i < 30; i++) run_cycle(rand_sw());
        async_clear();
        for (int i = 0; i < 7; i++) run_cycle(8'hFF);
        for (int i = 0; i < 400; i++) begin
            run_cycle(rand_sw());
            if (i == 123) async_clear();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule